// File: doc/BRIEF.md
# Averaged Signal Power Estimator

This block takes a stream of signed converter samples, qualified by a valid strobe, and adds up their squares over a window whose length is selected by a 3-bit field. When a window closes, it turns the mean power into a 4-bit code. The code is logarithmic, with about 1 dB per step, and code 15 sits at full-scale power. The block raises a one-cycle update strobe in the same cycle that the new code appears.

A second enable switches the same 4-bit port to a low-latency coarse code, which is the top four bits of the most recent accepted sample. When both enables are set, the coarse code wins. When neither is set, the port reads zero. The accumulator keeps running whichever mode is selected, so the latest power code is ready as soon as power mode is enabled.

Top module: `pwr_detect`

## Requirements
- R1: The window length is 2^(BASE_L2+s) valid samples for window select s from 0 to 4, and 2^(BASE_L2+4) for s from 5 to 7. The select is captured at the first sample of each window.
- R2: Only cycles with `smp_valid` high are counted and accumulated. Idle cycles neither extend nor shorten a window.
- R3: `det_upd` is high for exactly one cycle. That cycle follows the clock edge that accepts the last sample of a window, and the strobe is low at every other time.
- R4: The power code is computed from the mean M = floor(sum of squares / window length). With p the position of the leading one of M and f the bit just below it (0 when p = 0), the code is 3p + 2f - 63 clamped to 0..15 (14-bit samples). M = 0 gives code 0. M = 2^26 gives code 15.
- R5: In power mode, `det` takes the new code in the cycle `det_upd` is high and holds it until the next window closes. The code is refreshed even while power mode is disabled.
- R6: With `fast_en` set, `det` equals bits 13:10 of the last accepted sample, one cycle after it is accepted, and it holds over idle cycles.
- R7: With both enables set, `det` shows the coarse sample code.
- R8: With both enables clear, `det` is 0.
- R9: Reset, which is asynchronous and active low, clears `det`, `det_upd`, the stored code, the accumulator and the window position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample qualifier |
| smp | input | 14 | Signed sample |
| win_sel | input | 3 | Window length select |
| pwr_en | input | 1 | Power-code mode enable |
| fast_en | input | 1 | Coarse-sample mode enable (priority) |
| det | output | 4 | Detect code |
| det_upd | output | 1 | One-cycle window-complete strobe |

## Verification
Both results have a latency of one cycle. The power code and `det_upd` appear after the edge that accepts the last sample of a window. The coarse code appears after the edge that accepts its sample. The bench drives inputs on falling edges and checks on the next falling edge. It checks that `det_upd` stays low before every intermediate sample, which catches a wrong window length for any select value. It also inserts idle cycles inside windows and confirms that `det` holds and the strobe stays low.

// File: rtl/pwr_detect.sv
module pwr_detect #(
  parameter int SMP_W   = 14,
  parameter int BASE_L2 = 10,
  parameter int SEL_MAX = 4,
  parameter int CODE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp,
  input  logic [2:0]        win_sel,
  input  logic              pwr_en,
  input  logic              fast_en,
  output logic [CODE_W-1:0] det,
  output logic              det_upd
);
  localparam int SQ_W   = 2 * SMP_W;
  localparam int MAX_L2 = BASE_L2 + SEL_MAX;
  localparam int ACC_W  = SQ_W + MAX_L2;
  localparam int MEAN_W = SQ_W - 1;
  localparam int L2_W   = $clog2(MAX_L2 + 1);
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int OFFS   = 3 * (MEAN_W - 1) - CODE_MAX;

  logic [MAX_L2-1:0] cnt;
  logic [ACC_W-1:0]  acc, tot;
  logic [L2_W-1:0]   len_q, eff_l2, len_l2;
  logic [CODE_W-1:0] pwr_q, fast_q, code;
  logic signed [SQ_W-1:0] prod;
  logic [MEAN_W-1:0] mean;
  logic              last;

  assign eff_l2 = L2_W'(BASE_L2 + ((int'(win_sel) > SEL_MAX) ? SEL_MAX : int'(win_sel)));
  assign len_l2 = (cnt == '0) ? eff_l2 : len_q;
  assign last   = (32'(cnt) == (32'd1 << len_l2) - 32'd1);

  assign prod = $signed(smp) * $signed(smp);
  assign tot  = acc + ACC_W'($unsigned(prod));
  assign mean = MEAN_W'(tot >> len_l2);

  always_comb begin
    int p, raw;
    logic f;
    p = 0;
    f = 1'b0;
    for (int i = 1; i < MEAN_W; i++)
      if (mean[i]) begin
        p = i;
        f = mean[i-1];
      end
    raw = 3 * p + 2 * int'(f) - OFFS;
    if (mean == '0 || raw < 0) code = '0;
    else if (raw > CODE_MAX)   code = CODE_W'(CODE_MAX);
    else                       code = CODE_W'(raw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      acc     <= '0;
      len_q   <= '0;
      pwr_q   <= '0;
      fast_q  <= '0;
      det_upd <= 1'b0;
    end else begin
      det_upd <= 1'b0;
      if (smp_valid) begin
        fast_q <= smp[SMP_W-1 -: CODE_W];
        if (cnt == '0) len_q <= eff_l2;
        if (last) begin
          acc     <= '0;
          cnt     <= '0;
          pwr_q   <= code;
          det_upd <= 1'b1;
        end else begin
          acc <= tot;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign det = fast_en ? fast_q : (pwr_en ? pwr_q : '0);

  // R3: strobe never lasts two cycles
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    det_upd |=> !det_upd);
  // R3: strobe only follows an accepted sample
  a_r3_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    det_upd |-> ($past(smp_valid) && $past(rst_n)));
  // R1: window position stays inside the selected length
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < (32'd1 << len_l2));
  // R5: power code holds between updates
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_upd && pwr_en && !fast_en && $past(pwr_en && !fast_en) && $past(rst_n))
      |-> $stable(det));
  // R6: coarse code follows the accepted sample by one cycle
  a_r6_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && $past(smp_valid) && $past(rst_n))
      |-> det == $past(smp[SMP_W-1 -: CODE_W]));
endmodule

// File: tb/pwr_detect_test.sv
module pwr_detect_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [13:0] smp = '0;
  logic [2:0] win_sel = '0;
  logic pwr_en = 1'b0;
  logic fast_en = 1'b0;
  logic [3:0] det;
  logic det_upd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  pwr_detect #(.SMP_W(14), .BASE_L2(2), .SEL_MAX(4), .CODE_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp(smp),
    .win_sel(win_sel), .pwr_en(pwr_en), .fast_en(fast_en),
    .det(det), .det_upd(det_upd));

  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(longint a, longint b);
    longint m;
    int p, raw, f;
    m = (a * a + b * b) / 2;
    if (m == 0) return 0;
    p = 0;
    while ((m >> (p + 1)) != 0) p++;
    f = (p > 0) ? int'((m >> (p - 1)) & 1) : 0;
    raw = 3 * p + 2 * f - 63;
    if (raw < 0) return 0;
    if (raw > 15) return 15;
    return raw;
  endfunction

  function automatic int top4(int s);
    return (s & 16383) >> 10;
  endfunction

  task automatic run_window(int sel, int a, int b, int prev, int expc, bit gaps);
    int n;
    n = 4 << ((sel > 4) ? 4 : sel);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R3 no strobe mid-window (R1 length)", int'(det_upd), 0);
        if (pwr_en && !fast_en) check("R5 hold", int'(det), prev);
      end
      if (gaps && (i % 5 == 3)) begin
        smp_valid = 1'b0;
        smp = 14'(a ^ 14'h1555);
        @(negedge clk);
        check("R2 idle no strobe", int'(det_upd), 0);
      end
      win_sel = 3'(sel);
      smp = 14'((i % 2 == 1) ? b : a);
      smp_valid = 1'b1;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    win_sel = 3'(7 - sel);
    check("R3 strobe at window end", int'(det_upd), 1);
    check("R4 power code", int'(det), expc);
    @(negedge clk);
    check("R3 strobe one cycle", int'(det_upd), 0);
  endtask

  initial begin
    int pa[5] = '{0, -8192, 4000, 8191, 2000};
    int pb[5] = '{0, -8192, -3000, 100, -6000};
    int prev, e, last_s;
    repeat (3) @(negedge clk);
    check("R9 reset det", int'(det), 0);
    check("R9 reset strobe", int'(det_upd), 0);
    rst_n = 1'b1;
    pwr_en = 1'b1;
    prev = 0;
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 5; k++) begin
        e = exp_code(pa[k], pb[k]);
        run_window(s, pa[k], pb[k], prev, e, (k % 2 == 1));
        prev = e;
      end

    // R6/R7: coarse code with both enables set
    fast_en = 1'b1;
    last_s = 0;
    for (int s = -8192; s < 8192; s += 131) begin
      @(negedge clk);
      if (s != -8192) check("R7 R6 coarse code", int'(det), top4(last_s));
      smp = 14'(s);
      smp_valid = 1'b1;
      last_s = s;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    smp = 14'h2abc;
    check("R6 coarse code", int'(det), top4(last_s));
    @(negedge clk);
    check("R6 hold on idle", int'(det), top4(last_s));

    // R9 again, then R8
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset det", int'(det), 0);
    check("R9 reset strobe", int'(det_upd), 0);
    rst_n = 1'b1;
    fast_en = 1'b0;
    pwr_en = 1'b0;
    run_window(0, -8192, -8192, 0, 0, 1'b0);
    check("R8 both off", int'(det), 0);
    pwr_en = 1'b1;
    #1;
    check("R5 code refreshed while off", int'(det), 15);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule